// File: doc/BRIEF.md
# Video Domain Power Sequencer

This block walks a switchable video-processing power domain through its power-up and power-down sequences in hardware. It drives the main power-off switch control, the isolation clamp on the domain outputs, a bank of memory power-down controls, a group of reset lines and two clock enables. Firmware starts a sequence with a single-cycle request. The block then orders every control change itself and keeps the required settling time between changes. A status output gives the domain state, a busy flag covers the running sequence, and a one-cycle done pulse marks its end.

The memory power-down controls are switched one at a time. First come the fields of two wide control words, then a short run of bits in a third word, with a fixed settling time after each change. Every wait is a count of microseconds multiplied by the parameter `CYCLES_PER_US`. One down-counter serves all the waits, including the long hold after the power switch opens. A shutdown input forces a power-down, but only when the domain is up.

Top module: `vpd_sequencer`

## Requirements
- R1: During reset the block samples `boot_off_i`. If it is 1 the domain starts down: power-off 1, isolation 1, all memory controls 1, clocks 0, reset group 0, `powered_o` 0. If it is 0 the domain starts up: power-off 0, isolation 0, memory controls 0, clocks 1, `powered_o` 1. In both cases `busy_o`, `done_o` and `err_o` are 0.
- R2: A power-down sets isolation on the clock edge that samples the request. The first memory change follows ISO_US×CYCLES_PER_US cycles later.
- R3: Memory steps are numbered s = 0 .. 2·FIELDS+EXTRA_BITS−1. Steps 0..FIELDS−1 drive `mem_pd0_o[s]` and the next FIELDS steps drive `mem_pd1_o`. Each of these bits is the upper bit of two-bit field s of its word. The last EXTRA_BITS steps drive `mem_pd2_o` in ascending order; these stand for bits 8 and up of the third word. Only one control changes per step, and consecutive steps are STEP_US×CYCLES_PER_US cycles apart. A power-down sets the bits and a power-up clears them.
- R4: During power-down, the power-off control is set (STEP_US+SETTLE_US)×CYCLES_PER_US cycles after the last memory step. OFF_HOLD_US×CYCLES_PER_US cycles after that, clock A is disabled, and clock B is disabled on the following cycle.
- R5: A power-up clears the power-off control on the edge that samples the request. It then clears the memory controls in the R3 order, starting ISO_US×CYCLES_PER_US cycles later.
- R6: During power-up, the reset group rises (STEP_US+SETTLE_US)×CYCLES_PER_US cycles after the last memory step. The following changes then come one per cycle: isolation falls, the reset group falls, clock A is enabled, clock B is enabled.
- R7: `done_o` pulses for one cycle on the edge of the final step of a sequence. `powered_o` changes on that same edge. `busy_o` is 1 from the request edge until that edge.
- R8: A request that matches the current state pulses `done_o` on the next edge. It changes no control output and does not raise `busy_o`.
- R9: `shutdown_i` starts a power-down when the domain is up. When the domain is down it has no effect and gives no done pulse.
- R10: Any request seen while `busy_o` is 1 is ignored and sets `err_o`. `err_o` stays set until reset.
- R11: When requests arrive together while idle, the priority is: shutdown of an up domain, then power-down request, then power-up request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_off_i | input | 1 | Domain state at reset, 1 = down |
| on_req_i | input | 1 | Single-cycle power-up request |
| off_req_i | input | 1 | Single-cycle power-down request |
| shutdown_i | input | 1 | Forced power-down request |
| pwr_off_o | output | 1 | Main power switch control, 1 = off |
| iso_o | output | 1 | Output isolation clamp, 1 = clamped |
| rst_grp_o | output | RST_LINES | Domain reset lines, all alike |
| mem_pd0_o | output | FIELDS | Upper field bits of memory word 0 |
| mem_pd1_o | output | FIELDS | Upper field bits of memory word 1 |
| mem_pd2_o | output | EXTRA_BITS | Single-bit controls of memory word 2 |
| clk_a_en_o | output | 1 | First clock enable |
| clk_b_en_o | output | 1 | Second clock enable |
| powered_o | output | 1 | Domain is up |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence or matched request finished |
| err_o | output | 1 | Sticky flag: a request arrived while busy |

## Verification
Two events can land on the same edge: a new request, and the final step that pulses `done_o` and clears `busy_o`. The bench places a power-up request so that it is sampled on exactly the done edge of a running sequence. It expects the request to be dropped and `err_o` to rise, with the sequence outputs unchanged. A later request one cycle after completion must be accepted normally. Simultaneous requests in the idle state are provoked the same way, and every output is compared each cycle against an arithmetic timeline built from the wait lengths.

// File: rtl/vpd_seq_pkg.sv
package vpd_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FIRST_WAIT,
        S_MEM_WAIT,
        S_SETTLE,
        S_HOLD_WAIT,
        S_CLKB_OFF,
        S_ISO_REL,
        S_RST_REL,
        S_CLKA_ON,
        S_CLKB_ON
    } seq_state_e;

    typedef struct packed {
        logic pwr_off;
        logic iso;
        logic rst;
        logic clk_a;
        logic clk_b;
    } dom_ctl_t;

    function automatic int unsigned big4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned width_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/vpd_seq_timer.sv
module vpd_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/vpd_seq_memctl.sv
module vpd_seq_memctl #(
    parameter int unsigned STEPS = 40,
    parameter int unsigned IW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic             stb_i,
    input  logic [IW-1:0]    idx_i,
    input  logic             val_i,
    output logic [STEPS-1:0] pd_o
);
    logic [STEPS-1:0] pd_q;

    always_ff @(posedge clk) begin
        if (rst)
            pd_q <= {STEPS{init_i}};
        else if (stb_i && (int'(idx_i) < STEPS))
            pd_q[idx_i] <= val_i;
    end

    assign pd_o = pd_q;
endmodule

// File: rtl/vpd_seq_ctrl.sv
module vpd_seq_ctrl
    import vpd_seq_pkg::*;
#(
    parameter int unsigned STEPS   = 40,
    parameter int unsigned IW      = 6,
    parameter int unsigned TW      = 21,
    parameter int unsigned L_ISO   = 2000,
    parameter int unsigned L_STEP  = 500,
    parameter int unsigned L_SET   = 2000,
    parameter int unsigned L_HOLD  = 2000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_off_i,
    input  logic          on_req_i,
    input  logic          off_req_i,
    input  logic          shutdown_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          mem_stb_o,
    output logic [IW-1:0] mem_idx_o,
    output logic          mem_val_o,
    output dom_ctl_t      ctl_o,
    output logic          powered_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam logic [IW-1:0] LAST_STEP = IW'(STEPS - 1);
    localparam logic [TW-1:0] V_ISO  = TW'(L_ISO - 1);
    localparam logic [TW-1:0] V_STEP = TW'(L_STEP - 1);
    localparam logic [TW-1:0] V_SET  = TW'(L_SET - 1);
    localparam logic [TW-1:0] V_HOLD = TW'(L_HOLD - 1);

    seq_state_e    st_q, st_d;
    dom_ctl_t      ctl_q, ctl_d;
    logic [IW-1:0] step_q, step_d;
    logic          up_q, up_d;
    logic          pw_q, pw_d;
    logic          busy_q, busy_d;
    logic          err_q, err_d;
    logic          done_q, done_d;
    logic          any_req;

    assign any_req = on_req_i | off_req_i | shutdown_i;

    always_comb begin
        st_d       = st_q;
        ctl_d      = ctl_q;
        step_d     = step_q;
        up_d       = up_q;
        pw_d       = pw_q;
        busy_d     = busy_q;
        err_d      = err_q;
        done_d     = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        mem_stb_o  = 1'b0;
        mem_idx_o  = step_q;
        mem_val_o  = ~up_q;

        if (st_q != S_IDLE && any_req)
            err_d = 1'b1;

        case (st_q)
            S_IDLE: begin
                if (pw_q && (shutdown_i || off_req_i)) begin
                    ctl_d.iso  = 1'b1;
                    up_d       = 1'b0;
                    busy_d     = 1'b1;
                    step_d     = '0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = V_ISO;
                    st_d       = S_FIRST_WAIT;
                end else if (off_req_i) begin
                    done_d = 1'b1;
                end else if (on_req_i && !pw_q) begin
                    ctl_d.pwr_off = 1'b0;
                    up_d       = 1'b1;
                    busy_d     = 1'b1;
                    step_d     = '0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = V_ISO;
                    st_d       = S_FIRST_WAIT;
                end else if (on_req_i) begin
                    done_d = 1'b1;
                end
            end
            S_FIRST_WAIT: begin
                if (tmr_zero_i) begin
                    mem_stb_o  = 1'b1;
                    mem_idx_o  = step_q;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = V_STEP;
                    st_d       = S_MEM_WAIT;
                end
            end
            S_MEM_WAIT: begin
                if (tmr_zero_i) begin
                    if (step_q == LAST_STEP) begin
                        tmr_load_o = 1'b1;
                        tmr_val_o  = V_SET;
                        st_d       = S_SETTLE;
                    end else begin
                        step_d     = step_q + 1'b1;
                        mem_stb_o  = 1'b1;
                        mem_idx_o  = step_q + 1'b1;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = V_STEP;
                    end
                end
            end
            S_SETTLE: begin
                if (tmr_zero_i) begin
                    if (up_q) begin
                        ctl_d.rst = 1'b1;
                        st_d      = S_ISO_REL;
                    end else begin
                        ctl_d.pwr_off = 1'b1;
                        tmr_load_o    = 1'b1;
                        tmr_val_o     = V_HOLD;
                        st_d          = S_HOLD_WAIT;
                    end
                end
            end
            S_HOLD_WAIT: begin
                if (tmr_zero_i) begin
                    ctl_d.clk_a = 1'b0;
                    st_d        = S_CLKB_OFF;
                end
            end
            S_CLKB_OFF: begin
                ctl_d.clk_b = 1'b0;
                pw_d        = 1'b0;
                busy_d      = 1'b0;
                done_d      = 1'b1;
                st_d        = S_IDLE;
            end
            S_ISO_REL: begin
                ctl_d.iso = 1'b0;
                st_d      = S_RST_REL;
            end
            S_RST_REL: begin
                ctl_d.rst = 1'b0;
                st_d      = S_CLKA_ON;
            end
            S_CLKA_ON: begin
                ctl_d.clk_a = 1'b1;
                st_d        = S_CLKB_ON;
            end
            S_CLKB_ON: begin
                ctl_d.clk_b = 1'b1;
                pw_d        = 1'b1;
                busy_d      = 1'b0;
                done_d      = 1'b1;
                st_d        = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= S_IDLE;
            ctl_q.pwr_off <= boot_off_i;
            ctl_q.iso     <= boot_off_i;
            ctl_q.rst     <= 1'b0;
            ctl_q.clk_a   <= ~boot_off_i;
            ctl_q.clk_b   <= ~boot_off_i;
            step_q        <= '0;
            up_q          <= ~boot_off_i;
            pw_q          <= ~boot_off_i;
            busy_q        <= 1'b0;
            err_q         <= 1'b0;
            done_q        <= 1'b0;
        end else begin
            st_q   <= st_d;
            ctl_q  <= ctl_d;
            step_q <= step_d;
            up_q   <= up_d;
            pw_q   <= pw_d;
            busy_q <= busy_d;
            err_q  <= err_d;
            done_q <= done_d;
        end
    end

    assign ctl_o     = ctl_q;
    assign powered_o = pw_q;
    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign err_o     = err_q;
endmodule

// File: rtl/vpd_sequencer.sv
module vpd_sequencer
    import vpd_seq_pkg::*;
#(
    parameter int unsigned CYCLES_PER_US = 100,
    parameter int unsigned ISO_US        = 20,
    parameter int unsigned STEP_US       = 5,
    parameter int unsigned SETTLE_US     = 20,
    parameter int unsigned OFF_HOLD_US   = 20000,
    parameter int unsigned FIELDS        = 16,
    parameter int unsigned EXTRA_BITS    = 8,
    parameter int unsigned RST_LINES     = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_off_i,
    input  logic                  on_req_i,
    input  logic                  off_req_i,
    input  logic                  shutdown_i,
    output logic                  pwr_off_o,
    output logic                  iso_o,
    output logic [RST_LINES-1:0]  rst_grp_o,
    output logic [FIELDS-1:0]     mem_pd0_o,
    output logic [FIELDS-1:0]     mem_pd1_o,
    output logic [EXTRA_BITS-1:0] mem_pd2_o,
    output logic                  clk_a_en_o,
    output logic                  clk_b_en_o,
    output logic                  powered_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int unsigned STEPS  = 2 * FIELDS + EXTRA_BITS;
    localparam int unsigned IW     = width_for(STEPS - 1);
    localparam int unsigned L_ISO  = ISO_US * CYCLES_PER_US;
    localparam int unsigned L_STEP = STEP_US * CYCLES_PER_US;
    localparam int unsigned L_SET  = SETTLE_US * CYCLES_PER_US;
    localparam int unsigned L_HOLD = OFF_HOLD_US * CYCLES_PER_US;
    localparam int unsigned TW     = width_for(big4(L_ISO, L_STEP, L_SET, L_HOLD));

    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             mem_stb, mem_val;
    logic [IW-1:0]    mem_idx;
    logic [STEPS-1:0] pd_bits;
    dom_ctl_t         ctl;

    vpd_seq_ctrl #(
        .STEPS (STEPS), .IW (IW), .TW (TW),
        .L_ISO (L_ISO), .L_STEP (L_STEP), .L_SET (L_SET), .L_HOLD (L_HOLD)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .boot_off_i (boot_off_i),
        .on_req_i   (on_req_i),
        .off_req_i  (off_req_i),
        .shutdown_i (shutdown_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .mem_stb_o  (mem_stb),
        .mem_idx_o  (mem_idx),
        .mem_val_o  (mem_val),
        .ctl_o      (ctl),
        .powered_o  (powered_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    vpd_seq_timer #(.W (TW)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    vpd_seq_memctl #(.STEPS (STEPS), .IW (IW)) mem_i (
        .clk    (clk),
        .rst    (rst),
        .init_i (boot_off_i),
        .stb_i  (mem_stb),
        .idx_i  (mem_idx),
        .val_i  (mem_val),
        .pd_o   (pd_bits)
    );

    assign mem_pd0_o  = pd_bits[FIELDS-1:0];
    assign mem_pd1_o  = pd_bits[2*FIELDS-1:FIELDS];
    assign mem_pd2_o  = pd_bits[STEPS-1:2*FIELDS];
    assign pwr_off_o  = ctl.pwr_off;
    assign iso_o      = ctl.iso;
    assign rst_grp_o  = {RST_LINES{ctl.rst}};
    assign clk_a_en_o = ctl.clk_a;
    assign clk_b_en_o = ctl.clk_b;
endmodule

// File: rtl/vpd_seq_chk.sv
module vpd_seq_chk #(
    parameter int unsigned FIELDS     = 16,
    parameter int unsigned EXTRA_BITS = 8,
    parameter int unsigned RST_LINES  = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  on_req_i,
    input logic                  off_req_i,
    input logic                  shutdown_i,
    input logic                  pwr_off_o,
    input logic                  iso_o,
    input logic [RST_LINES-1:0]  rst_grp_o,
    input logic [FIELDS-1:0]     mem_pd0_o,
    input logic [FIELDS-1:0]     mem_pd1_o,
    input logic [EXTRA_BITS-1:0] mem_pd2_o,
    input logic                  clk_a_en_o,
    input logic                  clk_b_en_o,
    input logic                  powered_o,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  err_o
);
    localparam int unsigned STEPS = 2 * FIELDS + EXTRA_BITS;
    logic [STEPS-1:0] mem;
    assign mem = {mem_pd2_o, mem_pd1_o, mem_pd0_o};

    assert_iso_guards_mem_R2: assert property (@(posedge clk) disable iff (rst)
        ((mem & ~$past(mem)) != '0) |-> iso_o);

    assert_one_mem_step_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(mem ^ $past(mem)) <= 1);

    assert_pwr_off_after_mem_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_off_o) |-> (&mem));

    assert_clk_needs_power_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_a_en_o) || $rose(clk_b_en_o)) |-> (!pwr_off_o && !iso_o && !(|rst_grp_o)));

    assert_iso_release_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_o) |-> rst_grp_o[0]);

    assert_status_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        (powered_o != $past(powered_o)) |-> done_o);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_busy_req_err_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (on_req_i || off_req_i || shutdown_i)) |=> err_o);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind vpd_sequencer vpd_seq_chk #(
    .FIELDS (FIELDS), .EXTRA_BITS (EXTRA_BITS), .RST_LINES (RST_LINES)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .on_req_i   (on_req_i),
    .off_req_i  (off_req_i),
    .shutdown_i (shutdown_i),
    .pwr_off_o  (pwr_off_o),
    .iso_o      (iso_o),
    .rst_grp_o  (rst_grp_o),
    .mem_pd0_o  (mem_pd0_o),
    .mem_pd1_o  (mem_pd1_o),
    .mem_pd2_o  (mem_pd2_o),
    .clk_a_en_o (clk_a_en_o),
    .clk_b_en_o (clk_b_en_o),
    .powered_o  (powered_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/vpd_sequencer_tb.sv
module vpd_sequencer_tb_top;
    localparam int C    = 2;
    localparam int F    = 4;
    localparam int E    = 2;
    localparam int RL   = 3;
    localparam int N    = 2 * F + E;
    localparam int LI   = 3 * C;
    localparam int LS   = 1 * C;
    localparam int LSET = 2 * C;
    localparam int LO   = 5 * C;
    localparam int TP   = LI + N * LS + LSET;
    localparam int TDO  = TP + LO + 1;
    localparam int TR   = LI + N * LS + LSET;
    localparam int TDU  = TR + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boot_off = 1'b1;
    logic on_req = 1'b0, off_req = 1'b0, shut = 1'b0;
    logic pwr_off, iso, clk_a, clk_b, powered, busy, done, err;
    logic [RL-1:0] rstg;
    logic [F-1:0] m0, m1;
    logic [E-1:0] m2;

    int total = 0;
    int bad = 0;
    logic exp_err = 1'b0;

    always #5 clk = ~clk;

    vpd_sequencer #(
        .CYCLES_PER_US (C), .ISO_US (3), .STEP_US (1), .SETTLE_US (2),
        .OFF_HOLD_US (5), .FIELDS (F), .EXTRA_BITS (E), .RST_LINES (RL)
    ) dut_i (
        .clk (clk), .rst (rst), .boot_off_i (boot_off),
        .on_req_i (on_req), .off_req_i (off_req), .shutdown_i (shut),
        .pwr_off_o (pwr_off), .iso_o (iso), .rst_grp_o (rstg),
        .mem_pd0_o (m0), .mem_pd1_o (m1), .mem_pd2_o (m2),
        .clk_a_en_o (clk_a), .clk_b_en_o (clk_b), .powered_o (powered),
        .busy_o (busy), .done_o (done), .err_o (err)
    );

    typedef struct packed {
        logic pwr_off, iso, rst, clk_a, clk_b, done, busy, powered;
        logic [N-1:0] mem;
    } exp_t;

    // t = edges since the request edge (0 = the request edge itself)
    function automatic exp_t model(bit up, int t);
        exp_t e;
        if (!up) begin
            e.iso = 1'b1; e.rst = 1'b0;
            for (int s = 0; s < N; s++) e.mem[s] = (t >= LI + s * LS);
            e.pwr_off = (t >= TP);
            e.clk_a = !(t >= TP + LO);
            e.clk_b = !(t >= TDO);
            e.done = (t == TDO);
            e.busy = (t < TDO);
            e.powered = (t < TDO);
        end else begin
            e.pwr_off = 1'b0;
            for (int s = 0; s < N; s++) e.mem[s] = !(t >= LI + s * LS);
            e.rst = (t >= TR) && (t < TR + 2);
            e.iso = (t < TR + 1);
            e.clk_a = (t >= TR + 3);
            e.clk_b = (t >= TDU);
            e.done = (t == TDU);
            e.busy = (t < TDU);
            e.powered = (t >= TDU);
        end
        return e;
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic compare_all(string scen, bit up, exp_t e);
        cmp({scen, "/R2"}, "iso", 32'(iso), 32'(e.iso));
        cmp({scen, "/R3"}, "mem", 32'({m2, m1, m0}), 32'(e.mem));
        cmp({scen, up ? "/R5" : "/R4"}, "pwr_off", 32'(pwr_off), 32'(e.pwr_off));
        cmp({scen, "/R6"}, "rst_grp", 32'(rstg), e.rst ? 32'((1 << RL) - 1) : 32'd0);
        cmp({scen, up ? "/R6" : "/R4"}, "clk_a", 32'(clk_a), 32'(e.clk_a));
        cmp({scen, up ? "/R6" : "/R4"}, "clk_b", 32'(clk_b), 32'(e.clk_b));
        cmp({scen, "/R7"}, "done", 32'(done), 32'(e.done));
        cmp({scen, "/R7"}, "busy", 32'(busy), 32'(e.busy));
        cmp({scen, "/R7"}, "powered", 32'(powered), 32'(e.powered));
        cmp({scen, "/R10"}, "err", 32'(err), 32'(exp_err));
    endtask

    task automatic do_reset(bit boot);
        @(negedge clk);
        rst = 1'b1; boot_off = boot;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_err = 1'b0;
    endtask

    // steady state check for a number of cycles, no request
    task automatic check_idle(string scen, bit up, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare_all(scen, up, model(up, 1000));
        end
    endtask

    task automatic drive(bit on, bit off, bit sh);
        on_req = on; off_req = off; shut = sh;
    endtask

    // request matching the current state: done next edge, nothing else moves
    task automatic matched(string scen, bit up, bit on, bit off, bit sh);
        exp_t e;
        drive(on, off, sh);
        @(negedge clk);
        drive(0, 0, 0);
        e = model(up, 1000);
        e.done = 1'b1;
        compare_all(scen, up, e);
        @(negedge clk);
        compare_all(scen, up, model(up, 1000));
    endtask

    // full sequence with per-cycle comparison; inj = t at which an extra on_req is driven
    task automatic run_seq(string scen, bit up, bit on, bit off, bit sh, int inj);
        int td;
        td = up ? TDU : TDO;
        drive(on, off, sh);
        for (int t = 0; t <= td + 1; t++) begin
            @(negedge clk);
            drive(0, 0, 0);
            if (inj >= 0 && t >= inj + 1) exp_err = 1'b1;
            compare_all(scen, up, model(up, t));
            if (t == inj) on_req = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: boot into the down state
        do_reset(1'b1);
        check_idle("R1", 1'b0, 2);
        // R9: shutdown of a down domain has no effect, no done
        drive(0, 0, 1);
        check_idle("R9", 1'b0, 3);
        // R8: power-down request while down
        matched("R8", 1'b0, 0, 1, 0);
        // R11: on and off together while down -> off wins, matched
        matched("R11", 1'b0, 1, 1, 0);
        // R5: power-up
        run_seq("R5", 1'b1, 1, 0, 0, -1);
        // R8: power-up request while up
        matched("R8", 1'b1, 1, 0, 0);
        // R2: power-down
        run_seq("R2", 1'b0, 0, 1, 0, -1);
        // R10: request sampled on the done edge of a power-up is dropped
        run_seq("R10", 1'b1, 1, 0, 0, TDU - 1);
        // request right after completion is accepted (matched -> done)
        matched("R10", 1'b1, 1, 0, 0);
        // R11/R9: shutdown together with power-up while up -> power-down
        run_seq("R11", 1'b0, 1, 0, 1, -1);
        // R1: boot into the up state, error cleared
        do_reset(1'b0);
        check_idle("R1", 1'b1, 2);
        // R11: off and on together while up -> power-down
        run_seq("R11", 1'b0, 1, 1, 0, -1);
        // R10: mid-sequence request during power-up
        run_seq("R10", 1'b1, 1, 0, 0, 7);
        check_idle("R10", 1'b1, 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule